// File: doc/BRIEF.md
# Frequency-Select Mode Decoder and Clock Divider

This block turns four static strap pins into an operating mode for a system clock generator and derives every output clock group from one selected source. A frequency strap picks a 133 MHz or 100 MHz CPU setting. Two mode bits pick a spread option, a test mode or a board-test state in which every output floats. An active-low spread input turns the spread selection on or off. The spread modulation itself and the PLLs lie outside the block. The block only reports which spread flavour applies, and whether the 48 MHz PLL should run.

The two sources arrive as clock-enable strobes that are synchronous to the core clock `clk`. `vco_tick_i` marks each edge of the internal VCO, and `tclk_tick_i` marks each edge of the external test clock. Every group divider toggles its output once every N strobes of the selected source, so its period is N source periods. All dividers share one synchronous clear, so their phases stay locked to each other. When the strap pins change, the dividers are held cleared and every output enable is withdrawn for a short resynchronisation window. In normal modes the reference and 48 MHz groups pass through their own external sources (`ref_src_i`, `usb_src_i`). In test mode these two groups are also divided from the test clock. The block has no streaming data path: all pins are plain level controls and clocks.

Top module: `fsel_clkgen`

## Requirements
- R1: With `freq_hi_i`=0 and `mode_sel_i`=00, every bit of `oe_o` is 0, every clock output stays low, and `usb_pll_en_o` is 0.
- R2: With `freq_hi_i`=1 and `mode_sel_i`=00, `test_mode_o`=1 and all groups run from `tclk_tick_i`, with ratios CPU 2, half-CPU 4, 66 MHz 4, PCI 8, APIC 16, REF 1, 48 MHz 2 (ratio N gives a period of N source edges pairs, i.e. 2N strobes).
- R3: With `freq_hi_i`=1 and a non-zero mode code, the groups run from `vco_tick_i` with ratios CPU 1, half-CPU 2, 66 MHz 2, PCI 4, APIC 8.
- R4: With `freq_hi_i`=0 and a non-zero mode code, the groups run from `vco_tick_i` with ratios CPU 2, half-CPU 4, 66 MHz 3, PCI 6, APIC 12.
- R5: `spr_center_o`=1 exactly when `spread_n_i`=0 and `mode_sel_i`=01. `spr_down_o`=1 exactly when `spread_n_i`=0 and `mode_sel_i` is 10 or 11. Both flags are 0 when `spread_n_i`=1 or `mode_sel_i`=00.
- R6: `usb_pll_en_o` is 0 for `mode_sel_i`=01 and in the R1 state, and 1 otherwise. The 48 MHz group enable `oe_o[6]` follows it.
- R7: After any change of the strap pins, `oe_o` reads all zeros and all clock outputs are low for exactly 2 `clk` cycles, starting at the first rising edge that samples the change. The enables then return to their decoded values.
- R8: All groups count from a common clear. Every toggle of half-CPU coincides with a toggle of CPU, every PCI toggle with a 66 MHz toggle, and every APIC toggle with a PCI toggle.
- R9: In normal (non-test, non-R1) modes, `ref_clk_o` follows `ref_src_i` and `usb_clk_o` follows `usb_src_i` whenever their enables are set.
- R10: While `rst_n` is low, all clock outputs and all `oe_o` bits are 0.
- The bit positions of `oe_o` are fixed as follows: bit 0 CPU, bit 1 half-CPU, bit 2 66 MHz, bit 3 PCI, bit 4 APIC, bit 5 REF, bit 6 48 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, to which both source strobes are synchronous |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_hi_i | input | 1 | Frequency strap: 1 selects 133 MHz, 0 selects 100 MHz |
| mode_sel_i | input | 2 | Mode code |
| spread_n_i | input | 1 | Active-low spread enable |
| vco_tick_i | input | 1 | One strobe per internal VCO edge |
| tclk_tick_i | input | 1 | One strobe per external test clock edge |
| ref_src_i | input | 1 | Reference clock from the crystal path |
| usb_src_i | input | 1 | 48 MHz clock from its PLL |
| cpu_clk_o | output | 1 | CPU group clock |
| cpuhalf_clk_o | output | 1 | Half-rate CPU group clock |
| m66_clk_o | output | 1 | 66 MHz group clock |
| pci_clk_o | output | 1 | PCI group clock |
| apic_clk_o | output | 1 | Interrupt-controller group clock |
| ref_clk_o | output | 1 | Reference group clock |
| usb_clk_o | output | 1 | 48 MHz group clock |
| oe_o | output | 7 | Per-group output enable; 0 means high impedance |
| test_mode_o | output | 1 | Test clock selected |
| usb_pll_en_o | output | 1 | Enable for the 48 MHz PLL |
| spr_center_o | output | 1 | Centre spread requested |
| spr_down_o | output | 1 | Down spread requested |

## Verification
The bench builds the block with its defaults: a 5-bit ratio field and a 2-cycle resynchronisation window. The bench drives the VCO strobe every 2nd core cycle and the test strobe every 3rd, so a group running from the wrong source, or with the wrong ratio, shows a different measured period in core cycles. A 5-bit field reaches the largest test-mode ratio of 16. The bench walks all sixteen strap combinations. For each one it checks the enable window timing, the decoded flags, every enabled group's period, and that every disabled group stays low.

// File: rtl/fsel_clkgen_pkg.sv
package fsel_clkgen_pkg;

  localparam int NUM_GRP  = 7;
  localparam int GRP_CPU  = 0;
  localparam int GRP_HALF = 1;
  localparam int GRP_M66  = 2;
  localparam int GRP_PCI  = 3;
  localparam int GRP_APIC = 4;
  localparam int GRP_REF  = 5;
  localparam int GRP_USB  = 6;

  typedef enum logic [1:0] {
    OP_HIZ  = 2'd0,
    OP_TEST = 2'd1,
    OP_N100 = 2'd2,
    OP_N133 = 2'd3
  } op_mode_e;

  function automatic op_mode_e decode_op(input logic freq_hi, input logic [1:0] msel);
    if (msel == 2'b00) return freq_hi ? OP_TEST : OP_HIZ;
    return freq_hi ? OP_N133 : OP_N100;
  endfunction

  // Divide ratio (source periods per output period) for one group in one mode.
  function automatic int grp_ratio(input op_mode_e m, input int g);
    int r;
    r = 1;
    unique case (m)
      OP_TEST: begin
        case (g)
          GRP_CPU:  r = 2;
          GRP_HALF: r = 4;
          GRP_M66:  r = 4;
          GRP_PCI:  r = 8;
          GRP_APIC: r = 16;
          GRP_REF:  r = 1;
          default:  r = 2;
        endcase
      end
      OP_N133: begin
        case (g)
          GRP_CPU:  r = 1;
          GRP_HALF: r = 2;
          GRP_M66:  r = 2;
          GRP_PCI:  r = 4;
          GRP_APIC: r = 8;
          default:  r = 1;
        endcase
      end
      OP_N100: begin
        case (g)
          GRP_CPU:  r = 2;
          GRP_HALF: r = 4;
          GRP_M66:  r = 3;
          GRP_PCI:  r = 6;
          GRP_APIC: r = 12;
          default:  r = 1;
        endcase
      end
      default: r = 1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fsel_decode.sv
module fsel_decode
  import fsel_clkgen_pkg::*;
#(
  parameter int SYNC_CYCLES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     freq_hi_i,
  input  logic [1:0] mode_sel_i,
  input  logic     spread_n_i,
  output op_mode_e op_mode_o,
  output logic     busy_o,
  output logic     spr_center_o,
  output logic     spr_down_o,
  output logic     pll48_en_o
);

  localparam int SW = $clog2(SYNC_CYCLES + 1);

  logic [3:0]    pins_now;
  logic [3:0]    pins_q;
  logic [SW-1:0] sync_cnt;

  assign pins_now = {freq_hi_i, mode_sel_i, spread_n_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pins_q   <= '0;
      sync_cnt <= SW'(SYNC_CYCLES);
    end else begin
      pins_q <= pins_now;
      if (pins_now != pins_q)
        sync_cnt <= SW'(SYNC_CYCLES);
      else if (sync_cnt != '0)
        sync_cnt <= sync_cnt - 1'b1;
    end
  end

  logic       frq_q;
  logic [1:0] msel_q;
  logic       spr_n_q;
  assign frq_q   = pins_q[3];
  assign msel_q  = pins_q[2:1];
  assign spr_n_q = pins_q[0];

  assign op_mode_o    = decode_op(frq_q, msel_q);
  assign busy_o       = (sync_cnt != '0);
  assign spr_center_o = !spr_n_q && (msel_q == 2'b01);
  assign spr_down_o   = !spr_n_q && msel_q[1];
  assign pll48_en_o   = (op_mode_o != OP_HIZ) && (msel_q != 2'b01);

  assert_resync_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_now != pins_q) |=> busy_o);

  assert_spread_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(spr_center_o && spr_down_o));

  assert_pll_off_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode_o == OP_HIZ) |-> !pll48_en_o);

endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [RW-1:0] ratio,
  output logic          q_o
);

  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
      q_o <= 1'b0;
    end else if (tick) begin
      if (cnt == ratio - 1'b1) begin
        cnt <= '0;
        q_o <= ~q_o;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !$past(clr)) |-> (cnt < ratio));

endmodule

// File: rtl/fsel_clkgen.sv
module fsel_clkgen
  import fsel_clkgen_pkg::*;
#(
  parameter int RW          = 5,
  parameter int SYNC_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       freq_hi_i,
  input  logic [1:0] mode_sel_i,
  input  logic       spread_n_i,
  input  logic       vco_tick_i,
  input  logic       tclk_tick_i,
  input  logic       ref_src_i,
  input  logic       usb_src_i,
  output logic       cpu_clk_o,
  output logic       cpuhalf_clk_o,
  output logic       m66_clk_o,
  output logic       pci_clk_o,
  output logic       apic_clk_o,
  output logic       ref_clk_o,
  output logic       usb_clk_o,
  output logic [6:0] oe_o,
  output logic       test_mode_o,
  output logic       usb_pll_en_o,
  output logic       spr_center_o,
  output logic       spr_down_o
);

  op_mode_e           op_mode;
  logic               busy;
  logic               pll48_en;
  logic               tick;
  logic               grp_on;
  logic [NUM_GRP-1:0] div_q;

  fsel_decode #(.SYNC_CYCLES(SYNC_CYCLES)) u_decode (
    .clk          (clk),
    .rst_n        (rst_n),
    .freq_hi_i    (freq_hi_i),
    .mode_sel_i   (mode_sel_i),
    .spread_n_i   (spread_n_i),
    .op_mode_o    (op_mode),
    .busy_o       (busy),
    .spr_center_o (spr_center_o),
    .spr_down_o   (spr_down_o),
    .pll48_en_o   (pll48_en)
  );

  assign test_mode_o  = (op_mode == OP_TEST);
  assign tick         = test_mode_o ? tclk_tick_i : vco_tick_i;
  assign usb_pll_en_o = pll48_en;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [RW-1:0] ratio;
    assign ratio = RW'(grp_ratio(op_mode, g));
    tick_divider #(.RW(RW)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (busy),
      .tick  (tick),
      .ratio (ratio),
      .q_o   (div_q[g])
    );
  end

  assign grp_on = rst_n && !busy && (op_mode != OP_HIZ);
  assign oe_o   = {grp_on && pll48_en, {6{grp_on}}};

  assign cpu_clk_o     = oe_o[GRP_CPU]  && div_q[GRP_CPU];
  assign cpuhalf_clk_o = oe_o[GRP_HALF] && div_q[GRP_HALF];
  assign m66_clk_o     = oe_o[GRP_M66]  && div_q[GRP_M66];
  assign pci_clk_o     = oe_o[GRP_PCI]  && div_q[GRP_PCI];
  assign apic_clk_o    = oe_o[GRP_APIC] && div_q[GRP_APIC];
  assign ref_clk_o     = oe_o[GRP_REF]  && (test_mode_o ? div_q[GRP_REF] : ref_src_i);
  assign usb_clk_o     = oe_o[GRP_USB]  && (test_mode_o ? div_q[GRP_USB] : usb_src_i);

  assert_hiz_no_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == OP_HIZ) |-> (oe_o == '0 && !cpu_clk_o && !pci_clk_o));

  assert_phase_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(busy) && div_q[GRP_HALF] != $past(div_q[GRP_HALF]))
      |-> (div_q[GRP_CPU] != $past(div_q[GRP_CPU])));

  assert_phase_pci_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(busy) && div_q[GRP_PCI] != $past(div_q[GRP_PCI]))
      |-> (div_q[GRP_M66] != $past(div_q[GRP_M66])));

  assert_phase_apic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(busy) && div_q[GRP_APIC] != $past(div_q[GRP_APIC]))
      |-> (div_q[GRP_PCI] != $past(div_q[GRP_PCI])));

endmodule

// File: tb/fsel_clkgen_bench.sv
module fsel_clkgen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       freq_hi, spread_n;
  logic [1:0] msel;
  logic       vco_tick = 1'b0, tclk_tick = 1'b0, ref_src = 1'b0, usb_src = 1'b0;
  logic       cpu_clk, half_clk, m66_clk, pci_clk, apic_clk, ref_clk, usb_clk;
  logic [6:0] oe;
  logic       test_mode, pll_en, spr_c, spr_d;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int    grp;
    int    period;
    string req;
  } exp_item_t;
  exp_item_t exp_q[$];

  always #2.5 clk = ~clk;

  fsel_clkgen u_fsel_clkgen (
    .clk(clk), .rst_n(rst_n), .freq_hi_i(freq_hi), .mode_sel_i(msel),
    .spread_n_i(spread_n), .vco_tick_i(vco_tick), .tclk_tick_i(tclk_tick),
    .ref_src_i(ref_src), .usb_src_i(usb_src),
    .cpu_clk_o(cpu_clk), .cpuhalf_clk_o(half_clk), .m66_clk_o(m66_clk),
    .pci_clk_o(pci_clk), .apic_clk_o(apic_clk), .ref_clk_o(ref_clk),
    .usb_clk_o(usb_clk), .oe_o(oe), .test_mode_o(test_mode),
    .usb_pll_en_o(pll_en), .spr_center_o(spr_c), .spr_down_o(spr_d)
  );

  // Source strobes: VCO every 2nd cycle, test clock every 3rd; ref/usb sources
  // toggle every 5 / 7 cycles (periods 10 / 14).
  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      vco_tick  = (cyc % 2 == 0);
      tclk_tick = (cyc % 3 == 0);
      if (cyc % 5 == 0) ref_src = ~ref_src;
      if (cyc % 7 == 0) usb_src = ~usb_src;
    end
  end

  function automatic logic outbit(input int g);
    case (g)
      0: return cpu_clk;
      1: return half_clk;
      2: return m66_clk;
      3: return pci_clk;
      4: return apic_clk;
      5: return ref_clk;
      default: return usb_clk;
    endcase
  endfunction

  task automatic check(input int act, input int exp, input string req, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected period in core cycles, from the requirement ratios.
  function automatic int exp_period(input logic f, input logic [1:0] m, input int g);
    int rt[7];
    if (m == 2'b00) begin // test mode, R2, stride 3
      rt = '{2, 4, 4, 8, 16, 1, 2};
      return 2 * rt[g] * 3;
    end
    if (g == 5) return 10; // R9
    if (g == 6) return 14; // R9
    if (f) rt = '{1, 2, 2, 4, 8, 1, 1};   // R3
    else   rt = '{2, 4, 3, 6, 12, 1, 1};  // R4
    return 2 * rt[g] * 2;
  endfunction

  // Monitor: pops expected periods and measures the matching output.
  initial begin
    forever begin
      exp_item_t it;
      int n;
      logic pv, cv, rise;
      while (exp_q.size() == 0) @(negedge clk);
      it = exp_q[0];
      pv = outbit(it.grp);
      n = 0;
      do begin
        @(negedge clk); cv = outbit(it.grp); rise = cv && !pv; pv = cv; n++;
      end while (!rise && n < 600);
      n = 0;
      do begin
        @(negedge clk); cv = outbit(it.grp); rise = cv && !pv; pv = cv; n++;
      end while (!rise && n < 600);
      check(n, it.period, it.req, $sformatf("period of group %0d", it.grp));
      void'(exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    freq_hi = 1'b0; msel = 2'b11; spread_n = 1'b0;
    repeat (4) @(negedge clk);
    // R10: reset state
    check(int'(oe), 0, "R10", "oe in reset");
    check(int'({cpu_clk, half_clk, m66_clk, pci_clk, apic_clk, ref_clk, usb_clk}), 0,
          "R10", "clocks in reset");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    for (int idx = 0; idx < 16; idx++) begin
      logic f, s, tri_m, tst;
      logic [1:0] m;
      logic [6:0] exp_oe;
      string rq;
      f = idx[3]; m = idx[2:1]; s = idx[0];
      tri_m = !f && m == 2'b00;
      tst   = f && m == 2'b00;
      exp_oe = tri_m ? 7'h00 : (m == 2'b01 ? 7'h3F : 7'h7F);
      rq = tst ? "R2" : (f ? "R3" : "R4");

      @(negedge clk);
      freq_hi = f; msel = m; spread_n = s;
      // R7: two-cycle resynchronisation window
      @(posedge clk); @(negedge clk);
      check(int'(oe), 0, "R7", "oe window cycle 1");
      check(int'(cpu_clk), 0, "R7", "cpu low window cycle 1");
      @(posedge clk); @(negedge clk);
      check(int'(oe), 0, "R7", "oe window cycle 2");
      @(posedge clk); @(negedge clk);
      check(int'(oe), int'(exp_oe), tri_m ? "R1" : "R6", "oe after window");
      check(int'(pll_en), int'(!tri_m && m != 2'b01), "R6", "usb pll enable");
      check(int'(test_mode), int'(tst), "R2", "test mode flag");
      check(int'(spr_c), int'(!s && m == 2'b01), "R5", "centre spread flag");
      check(int'(spr_d), int'(!s && m[1]), "R5", "down spread flag");

      for (int g = 0; g < 7; g++) begin
        if (exp_oe[g]) begin
          exp_item_t it;
          it.grp = g;
          it.period = exp_period(f, m, g);
          it.req = (!tst && g >= 5) ? "R9" : rq;
          exp_q.push_back(it);
        end
      end
      while (exp_q.size() != 0) @(negedge clk);

      // Disabled groups must stay low (R1, R6)
      if (exp_oe != 7'h7F) begin
        int hi;
        hi = 0;
        for (int k = 0; k < 60; k++) begin
          @(negedge clk);
          for (int g = 0; g < 7; g++)
            if (!exp_oe[g] && outbit(g)) hi++;
        end
        check(hi, 0, tri_m ? "R1" : "R6", "disabled group high samples");
      end

      // R8: phase lock between group pairs
      if (!tri_m) begin
        int bad;
        logic pc, ph, pm, pp, pa;
        bad = 0;
        @(negedge clk);
        pc = cpu_clk; ph = half_clk; pm = m66_clk; pp = pci_clk; pa = apic_clk;
        for (int k = 0; k < 200; k++) begin
          @(negedge clk);
          if (half_clk != ph && cpu_clk == pc) bad++;
          if (pci_clk != pp && m66_clk == pm) bad++;
          if (apic_clk != pa && pci_clk == pp) bad++;
          pc = cpu_clk; ph = half_clk; pm = m66_clk; pp = pci_clk; pa = apic_clk;
        end
        check(bad, 0, "R8", "unaligned toggles");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule